// File: doc/BRIEF.md
# Load/Store Alignment Unit

This block sits between a processor's execute stage and a 32-bit data memory port. For each memory operation it takes a six-bit operation code, forms the effective address by adding operand A to either operand B or a pre-extended immediate, and chooses the access size (byte, halfword or word). Misaligned addresses never raise a fault. The unit clears the low address bits that the access size does not allow.

For a store, the unit drives the memory port in the same cycle with the aligned address, a write strobe, four byte-lane enables and the write data. The byte, halfword or word from the store operand is copied across every lane. For a load, the unit drives the aligned address in the same cycle. The memory returns its read word one cycle later. The unit then selects the addressed byte or halfword, zero-extends it to 32 bits, and raises a result-valid flag for that one cycle. Memory is big-endian: address offset 0 maps to data bits 31:24.

Top module: `lsu_align_unit`

## Requirements
- R1: When opcode bit 3 is 0, the effective address is `opnd_a + opnd_b`. When bit 3 is 1, it is `opnd_a + imm_ext`. Both sums wrap modulo 2^32.
- R2: An operation is accepted only when `req_valid` is 1, opcode bits 5:4 are `11`, and opcode bits 1:0 are not `11`. Bit 2 selects store (1) or load (0). Bits 1:0 give the size: 0 is byte, 1 is halfword, 2 is word. An accepted operation raises `mem_req` in the same cycle, and `mem_we` equals bit 2. Any other input leaves `mem_req` and `mem_we` at 0.
- R3: `mem_addr` is the effective address with bit 0 cleared for a halfword and bits 1:0 cleared for a word. A byte access uses the full effective address.
- R4: For a store, `mem_be` follows the size and the effective-address bits 1:0. `mem_be[3]` covers data bits 31:24. A byte at offset k enables `mem_be[3-k]`. A halfword with offset bit 1 = 0 gives `1100`, otherwise `0011`. A word gives `1111`. `mem_be` is `0000` whenever no store is accepted.
- R5: Store data is copied across the lanes. A byte store gives four copies of `store_val[7:0]`, a halfword store gives two copies of `store_val[15:0]`, and a word store gives `store_val` unchanged.
- R6: `ld_valid` is 1 in exactly the cycle after an accepted load. It stays 0 after a store, after an unaccepted input, and after an idle cycle.
- R7: A byte load returns `mem_rdata[31-8k -: 8]`, where k is the effective-address bits 1:0, zero-extended to 32 bits.
- R8: A halfword load returns `mem_rdata[31:16]` when offset bit 1 is 0 and `mem_rdata[15:0]` when it is 1, zero-extended to 32 bits.
- R9: A word load returns `mem_rdata` unchanged.
- R10: After a synchronous active-high reset, `ld_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | An operation is presented this cycle |
| opcode | input | 6 | Operation code |
| opnd_a | input | ADDR_W (32) | Base operand |
| opnd_b | input | ADDR_W (32) | Register offset operand |
| imm_ext | input | ADDR_W (32) | Sign-extended immediate offset |
| store_val | input | 32 | Store source operand |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write strobe |
| mem_addr | output | ADDR_W (32) | Aligned memory address |
| mem_be | output | 4 | Byte-lane write enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_rdata | input | 32 | Read word, valid one cycle after a load request |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extracted, zero-extended load result |

## Verification
The address, strobes, byte enables and write data are combinational, so they are due in the same cycle as the request. The bench checks them shortly after driving the inputs on the falling edge, before the next rising edge. A load result is due one rising edge later. Each load task crosses one rising edge, then supplies the read word and checks `ld_valid` and `ld_data` on the next falling edge. Store and rejected cases check at that same point that `ld_valid` stays low.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_NONE = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic      legal;
        logic      is_store;
        logic      use_imm;
        acc_size_e size;
    } op_info_t;

    function automatic op_info_t decode_op(input logic [5:0] op);
        op_info_t r;
        r.use_imm  = op[3];
        r.is_store = op[2];
        r.size     = acc_size_e'(op[1:0]);
        r.legal    = (op[5:4] == 2'b11) && (op[1:0] != 2'b11);
        return r;
    endfunction

    function automatic logic [1:0] low_mask(input acc_size_e sz);
        case (sz)
            SZ_HALF: return 2'b10;
            SZ_WORD: return 2'b00;
            default: return 2'b11;
        endcase
    endfunction

    function automatic logic [LANES-1:0] lane_enables(input acc_size_e sz,
                                                      input logic [1:0] off);
        case (sz)
            SZ_BYTE: return 4'b1000 >> off;
            SZ_HALF: return off[1] ? 4'b0011 : 4'b1100;
            SZ_WORD: return 4'b1111;
            default: return 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              req_valid,
    input  logic [5:0]        opcode,
    input  logic [ADDR_W-1:0] opnd_a,
    input  logic [ADDR_W-1:0] opnd_b,
    input  logic [ADDR_W-1:0] imm_ext,
    output op_info_t          info,
    output logic              fire,
    output logic [1:0]        ea_off,
    output logic [ADDR_W-1:0] addr_al
);
    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] ea;

    always_comb begin
        info    = decode_op(opcode);
        fire    = req_valid && info.legal;
        offset  = info.use_imm ? imm_ext : opnd_b;
        ea      = opnd_a + offset;
        ea_off  = ea[1:0];
        addr_al = {ea[ADDR_W-1:2], ea[1:0] & low_mask(info.size)};
    end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
    import lsu_pkg::*;
(
    input  logic              st_fire,
    input  acc_size_e         size,
    input  logic [1:0]        off,
    input  logic [DATA_W-1:0] store_val,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] wdata
);
    assign be = st_fire ? lane_enables(size, off) : '0;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            case (size)
                SZ_BYTE: wdata[g*8 +: 8] = store_val[7:0];
                SZ_HALF: wdata[g*8 +: 8] = store_val[(g % 2)*8 +: 8];
                default: wdata[g*8 +: 8] = store_val[g*8 +: 8];
            endcase
        end
    end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_fire,
    input  acc_size_e         size,
    input  logic [1:0]        off,
    input  logic [DATA_W-1:0] rdata,
    output logic              ld_valid,
    output logic [DATA_W-1:0] ld_data
);
    acc_size_e  size_q;
    logic [1:0] off_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_valid <= 1'b0;
            size_q   <= SZ_WORD;
            off_q    <= 2'b00;
        end else begin
            ld_valid <= ld_fire;
            if (ld_fire) begin
                size_q <= size;
                off_q  <= off;
            end
        end
    end

    always_comb begin
        case (size_q)
            SZ_BYTE: ld_data = {24'b0, rdata[8*(3 - off_q) +: 8]};
            SZ_HALF: ld_data = {16'b0, off_q[1] ? rdata[15:0] : rdata[31:16]};
            default: ld_data = rdata;
        endcase
    end

    // R7
    byte_zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && size_q == SZ_BYTE) |-> (ld_data[31:8] == 24'b0));
    // R8
    half_zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && size_q == SZ_HALF) |-> (ld_data[31:16] == 16'b0));
endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [5:0]        opcode,
    input  logic [ADDR_W-1:0] opnd_a,
    input  logic [ADDR_W-1:0] opnd_b,
    input  logic [ADDR_W-1:0] imm_ext,
    input  logic [31:0]       store_val,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              ld_valid,
    output logic [31:0]       ld_data
);
    op_info_t   info;
    logic       fire;
    logic [1:0] ea_off;

    lsu_agen #(.ADDR_W(ADDR_W)) u_agen (
        .req_valid (req_valid),
        .opcode    (opcode),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .imm_ext   (imm_ext),
        .info      (info),
        .fire      (fire),
        .ea_off    (ea_off),
        .addr_al   (mem_addr)
    );

    assign mem_req = fire;
    assign mem_we  = fire && info.is_store;

    lsu_store_lane u_store (
        .st_fire   (mem_we),
        .size      (info.size),
        .off       (ea_off),
        .store_val (store_val),
        .be        (mem_be),
        .wdata     (mem_wdata)
    );

    lsu_load_extract u_load (
        .clk      (clk),
        .rst      (rst),
        .ld_fire  (fire && !info.is_store),
        .size     (info.size),
        .off      (ea_off),
        .rdata    (mem_rdata),
        .ld_valid (ld_valid),
        .ld_data  (ld_data)
    );

    // R6
    load_returns_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |=> ld_valid);
    // R6
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_req && !mem_we) |=> !ld_valid);
    // R4
    be_store_only_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_we |-> (mem_be == 4'b0000));
    // R3
    word_align_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mem_be == 4'b1111) |-> (mem_addr[1:0] == 2'b00));
    // R4
    be_shape_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ($countones(mem_be) inside {1, 2, 4}));
    // R2
    we_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_req);
endmodule

// File: tb/tb_lsu_align_unit.sv
module tb_lsu_align_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [5:0]  opcode;
    logic [31:0] opnd_a, opnd_b, imm_ext, store_val, mem_rdata;
    logic        mem_req, mem_we, ld_valid;
    logic [31:0] mem_addr, mem_wdata, ld_data;
    logic [3:0]  mem_be;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    lsu_align_unit dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .opcode(opcode),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .imm_ext(imm_ext),
        .store_val(store_val), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .ld_valid(ld_valid), .ld_data(ld_data)
    );

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [5:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] im,
                         input logic [31:0] sv);
        @(negedge clk);
        req_valid = 1'b1; opcode = op; opnd_a = a; opnd_b = b;
        imm_ext = im; store_val = sv;
        #1;
    endtask

    task automatic do_load(input logic [5:0] op, input logic [31:0] a,
                           input logic [31:0] b, input logic [31:0] im,
                           input logic [31:0] rd, input logic [31:0] exp_addr,
                           input logic [31:0] exp_data, input string tag);
        drive(op, a, b, im, 32'h0);
        check(mem_req && !mem_we, {tag, " R2 load strobe"}, {30'b0, mem_req, mem_we}, 32'h2);
        check(mem_addr == exp_addr, {tag, " R1/R3 address"}, mem_addr, exp_addr);
        check(mem_be == 4'b0, {tag, " R4 no enables on load"}, {28'b0, mem_be}, 32'h0);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; mem_rdata = rd;
        #1;
        check(ld_valid, {tag, " R6 valid next cycle"}, {31'b0, ld_valid}, 32'h1);
        check(ld_data == exp_data, {tag, " R7/R8/R9 data"}, ld_data, exp_data);
    endtask

    task automatic do_store(input logic [5:0] op, input logic [31:0] a,
                            input logic [31:0] b, input logic [31:0] im,
                            input logic [31:0] sv, input logic [31:0] exp_addr,
                            input logic [3:0] exp_be, input logic [31:0] exp_wd,
                            input string tag);
        drive(op, a, b, im, sv);
        check(mem_req && mem_we, {tag, " R2 store strobe"}, {30'b0, mem_req, mem_we}, 32'h3);
        check(mem_addr == exp_addr, {tag, " R1/R3 address"}, mem_addr, exp_addr);
        check(mem_be == exp_be, {tag, " R4 enables"}, {28'b0, mem_be}, {28'b0, exp_be});
        check(mem_wdata == exp_wd, {tag, " R5 write data"}, mem_wdata, exp_wd);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check(!ld_valid, {tag, " R6 no valid after store"}, {31'b0, ld_valid}, 32'h0);
    endtask

    task automatic do_reject(input logic rv, input logic [5:0] op, input string tag);
        drive(op, 32'h100, 32'h4, 32'h8, 32'h55);
        req_valid = rv;
        #1;
        check(!mem_req && !mem_we, {tag, " R2 rejected"}, {30'b0, mem_req, mem_we}, 32'h0);
        check(mem_be == 4'b0, {tag, " R4 no enables"}, {28'b0, mem_be}, 32'h0);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check(!ld_valid, {tag, " R6 no valid"}, {31'b0, ld_valid}, 32'h0);
    endtask

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; opcode = '0; opnd_a = '0; opnd_b = '0;
        imm_ext = '0; store_val = '0; mem_rdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(!ld_valid && !mem_req, "R10 reset state", {30'b0, ld_valid, mem_req}, 32'h0);

        do_load(6'h30, 32'h1000, 32'h3, 32'h0, 32'hAABBCCDD, 32'h1003, 32'h000000DD, "R7 byte reg off3");
        do_load(6'h38, 32'h1000, 32'h0, 32'h1, 32'hAABBCCDD, 32'h1001, 32'h000000BB, "R7 byte imm off1");
        do_load(6'h38, 32'h1000, 32'h0, 32'hFFFFFFFC, 32'h8899AABB, 32'h0FFC, 32'h00000088, "R1 byte negative imm");
        do_load(6'h31, 32'h2000, 32'h3, 32'h0, 32'hAABBCCDD, 32'h2002, 32'h0000CCDD, "R8 half low");
        do_load(6'h39, 32'h2000, 32'h0, 32'h1, 32'hAABBCCDD, 32'h2000, 32'h0000AABB, "R8 half high");
        do_load(6'h3A, 32'h3000, 32'h0, 32'h7, 32'h12345678, 32'h3004, 32'h12345678, "R9 word imm");
        do_load(6'h32, 32'hFFFFFFFF, 32'h2, 32'h0, 32'hCAFEF00D, 32'h0, 32'hCAFEF00D, "R1 word wrap");

        do_store(6'h34, 32'h10, 32'h2, 32'h0, 32'h123456EF, 32'h12, 4'b0010, 32'hEFEFEFEF, "R4 byte off2");
        do_store(6'h3C, 32'h10, 32'h0, 32'h0, 32'h00000077, 32'h10, 4'b1000, 32'h77777777, "R4 byte off0");
        do_store(6'h34, 32'h10, 32'h3, 32'h0, 32'hFFFFFF01, 32'h13, 4'b0001, 32'h01010101, "R5 byte off3");
        do_store(6'h35, 32'h20, 32'h3, 32'h0, 32'hDEAD1234, 32'h22, 4'b0011, 32'h12341234, "R5 half low");
        do_store(6'h3D, 32'h20, 32'h0, 32'h1, 32'hDEADBEEF, 32'h20, 4'b1100, 32'hBEEFBEEF, "R3 half high");
        do_store(6'h3E, 32'h40, 32'h0, 32'h3, 32'h89ABCDEF, 32'h40, 4'b1111, 32'h89ABCDEF, "R3 word imm");
        do_store(6'h36, 32'h40, 32'h6, 32'h0, 32'h0BADCAFE, 32'h44, 4'b1111, 32'h0BADCAFE, "R5 word reg");

        do_reject(1'b1, 6'h33, "R2 size3 load");
        do_reject(1'b1, 6'h3F, "R2 size3 store");
        do_reject(1'b1, 6'h2E, "R2 out of range");
        do_reject(1'b0, 6'h32, "R2 idle valid op");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule